// File: doc/BRIEF.md
# Scatter-Gather Sector DMA Engine

This block moves one disk or optical transfer between a drive-side sector buffer and system memory, guided by a table of region descriptors in memory. A start pulse fixes the direction, the media type, a starting logical block address and a length given as a sector count. The engine then fetches descriptors one by one and copies data in chunks. Each chunk is no larger than one sector. Each chunk is one handshake on the drive side and one request on the memory side.

Every descriptor is checked at its end. A descriptor must end on a sector boundary of the total transfer. A table that ends before the length is covered is a hard error. On a clean finish the engine pulses done and its interrupt. If the last descriptor used carried the end-of-table flag, it also returns the drive status to idle and drops its active flag. The table position survives from one run to the next until it is cleared explicitly.

Top module: `sgdma_engine`

## Requirements
- R1: After reset the engine is idle (busy low, no memory or sector request), active and dma_err are low, drv_stat is 0x50 and the table index is 0.
- R2: Descriptor i is read with a memory request of length 8 at tbl_base + 8*i, with mem_we low. The returned word holds the region base in bits [31:0], the byte count in bits [47:32] and the end-of-table flag in bit 48. A byte count of 0 means 65536.
- R3: Each chunk moves min(descriptor bytes left, transfer bytes left, sector size) bytes, where the sector size is 512 with optical low and 2048 with optical high. Its memory address is the region base plus the bytes already moved in that descriptor. A descriptor ends when its bytes or the transfer's bytes run out.
- R4: With dir_to_mem high, each chunk is a sector request (sec_wr low) followed by a memory write (mem_we high). With it low, each chunk is a memory read followed by a sector request with sec_wr high. Memory and sector requests are never raised together.
- R5: The first chunk carries sec_lba equal to lba_in, and every completed chunk raises the block address by one.
- R6: The transfer length is sect_cnt times 512 bytes, and a sect_cnt of 0 means 256 sectors.
- R7: The table index advances once per descriptor ended and is kept across runs. idx_clear resets it only while idle. start and idx_clear have no effect while busy.
- R8: If the bytes moved so far are not a multiple of the sector size when a descriptor ends, the run stops: err pulses, dma_err goes high, active goes low, drv_stat becomes 0x41, and irq and done stay low.
- R9: If a descriptor with the end-of-table flag ends while bytes remain, the run stops with the same error response as R8.
- R10: When all bytes are moved and the last descriptor had end-of-table set, done and irq pulse together for one cycle, drv_stat becomes 0x50 and active goes low.
- R11: When all bytes are moved but the last descriptor lacked end-of-table, done and irq still pulse, but drv_stat keeps its busy value 0x80 and active stays high.
- R12: A memory or sector request stays high with unchanged address, length and direction fields until its acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| dir_to_mem | input | 1 | 1: drive to memory, 0: memory to drive |
| optical | input | 1 | 1: 2048-byte sectors, 0: 512-byte sectors |
| sect_cnt | input | 8 | Transfer length in 512-byte sectors, 0 means 256 |
| lba_in | input | 28 | Starting logical block address |
| tbl_base | input | 32 | Address of descriptor 0 |
| idx_clear | input | 1 | Reset the table index while idle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory request address |
| mem_len | output | 12 | Memory request length in bytes |
| mem_ack | input | 1 | Memory request complete |
| mem_rdata | input | 49 | Descriptor word returned with the acknowledge of a fetch |
| sec_req | output | 1 | Sector buffer request |
| sec_wr | output | 1 | Sector request moves buffer data to the drive |
| sec_lba | output | 28 | Block address of the chunk |
| sec_len | output | 12 | Chunk length in bytes |
| sec_ack | input | 1 | Sector request complete |
| busy | output | 1 | A run is in progress |
| active | output | 1 | DMA active flag |
| dma_err | output | 1 | Sticky error flag of the last run |
| drv_stat | output | 8 | Drive status byte |
| done | output | 1 | One-cycle pulse at a clean finish |
| err | output | 1 | One-cycle pulse at an aborted run |
| irq | output | 1 | One-cycle interrupt pulse at a clean finish |

## Verification
The runs cover both directions. They use one-descriptor and multi-descriptor tables, optical chunking, and maximum counts of zero in both the sector count and the descriptor count, so that the chunk size and the ordering of sector and memory requests can be told apart. A descriptor of 256 bytes and a table that ends too early separate the two error paths from each other and from a clean finish. A table whose last used entry has no end-of-table flag separates the interrupt from the status update. Back-to-back runs without a clear, with start and idx_clear pulses during a run, show whether the index persists and whether the busy-time inputs are ignored.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_STG1,
    S_STG2,
    S_DEND
  } sg_state_t;

  localparam logic [7:0] STAT_IDLE = 8'h50;
  localparam logic [7:0] STAT_BUSY = 8'h80;
  localparam logic [7:0] STAT_ERR  = 8'h41;
endpackage

// File: rtl/sgdma_chunk_calc.sv
module sgdma_chunk_calc #(
  parameter int DLEFT_W   = 17,
  parameter int LEN_W     = 18,
  parameter int CHK_W     = 12,
  parameter int DISK_SECT = 512,
  parameter int OPT_SECT  = 2048
) (
  input  logic [DLEFT_W-1:0] dleft,
  input  logic [LEN_W-1:0]   tleft,
  input  logic [LEN_W-1:0]   xfer,
  input  logic               optical,
  output logic [CHK_W-1:0]   chunk,
  output logic               last,
  output logic               misalign
);
  localparam int W = (DLEFT_W > LEN_W) ? DLEFT_W : LEN_W;

  logic [W-1:0] d_e, t_e, s_e, m1, m2;

  assign d_e = W'(dleft);
  assign t_e = W'(tleft);
  assign s_e = optical ? W'(OPT_SECT) : W'(DISK_SECT);
  assign m1  = (d_e < t_e) ? d_e : t_e;
  assign m2  = (m1 < s_e) ? m1 : s_e;

  assign chunk    = CHK_W'(m2);
  assign last     = (m2 == d_e) || (m2 == t_e);
  assign misalign = optical ? |(xfer & LEN_W'(OPT_SECT - 1))
                            : |(xfer & LEN_W'(DISK_SECT - 1));
endmodule

// File: rtl/sgdma_idx_reg.sv
module sgdma_idx_reg #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  input  logic [ADDR_W-1:0] tbl_base,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam int ENTRY_SHIFT = 3;

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || clr) idx <= '0;
    else if (adv)   idx <= idx + 1'b1;
  end

  assign entry_addr = tbl_base + (ADDR_W'(idx) << ENTRY_SHIFT);
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine #(
  parameter int ADDR_W    = 32,
  parameter int LBA_W     = 28,
  parameter int IDX_W     = 8,
  parameter int SCNT_W    = 8,
  parameter int DCNT_W    = 16,
  parameter int DISK_SECT = 512,
  parameter int OPT_SECT  = 2048,
  localparam int DESC_W   = ADDR_W + DCNT_W + 1,
  localparam int CHK_W    = $clog2(OPT_SECT) + 1,
  localparam int LEN_W    = SCNT_W + 1 + $clog2(DISK_SECT),
  localparam int DLEFT_W  = DCNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_to_mem,
  input  logic              optical,
  input  logic [SCNT_W-1:0] sect_cnt,
  input  logic [LBA_W-1:0]  lba_in,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              idx_clear,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CHK_W-1:0]  mem_len,
  input  logic              mem_ack,
  input  logic [DESC_W-1:0] mem_rdata,
  output logic              sec_req,
  output logic              sec_wr,
  output logic [LBA_W-1:0]  sec_lba,
  output logic [CHK_W-1:0]  sec_len,
  input  logic              sec_ack,
  output logic              busy,
  output logic              active,
  output logic              dma_err,
  output logic [7:0]        drv_stat,
  output logic              done,
  output logic              err,
  output logic              irq
);
  import sgdma_pkg::*;

  localparam int DESC_LEN = 8;

  sg_state_t           st;
  logic                to_mem_q, opt_q, eot_q;
  logic [LEN_W-1:0]    tleft, xfer, total_len;
  logic [DLEFT_W-1:0]  dleft, doff;
  logic [ADDR_W-1:0]   dbase, entry_addr;
  logic [LBA_W-1:0]    lba_q;
  logic [CHK_W-1:0]    chunk;
  logic                last_chunk, misalign, stg_ack;
  logic [DCNT_W-1:0]   rd_cnt;

  assign total_len = LEN_W'({(sect_cnt == '0), sect_cnt}) << $clog2(DISK_SECT);
  assign rd_cnt    = mem_rdata[ADDR_W +: DCNT_W];

  sgdma_chunk_calc #(
    .DLEFT_W(DLEFT_W), .LEN_W(LEN_W), .CHK_W(CHK_W),
    .DISK_SECT(DISK_SECT), .OPT_SECT(OPT_SECT)
  ) u_chunk (
    .dleft(dleft), .tleft(tleft), .xfer(xfer), .optical(opt_q),
    .chunk(chunk), .last(last_chunk), .misalign(misalign)
  );

  sgdma_idx_reg #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_idx (
    .clk(clk), .rst(rst),
    .clr(st == S_IDLE && idx_clear),
    .adv(st == S_DEND),
    .tbl_base(tbl_base),
    .entry_addr(entry_addr)
  );

  assign mem_req  = (st == S_FETCH) || (st == S_STG1 && !to_mem_q) || (st == S_STG2 && to_mem_q);
  assign sec_req  = (st == S_STG1 && to_mem_q) || (st == S_STG2 && !to_mem_q);
  assign mem_we   = (st != S_FETCH) && to_mem_q;
  assign mem_addr = (st == S_FETCH) ? entry_addr : dbase + ADDR_W'(doff);
  assign mem_len  = (st == S_FETCH) ? CHK_W'(DESC_LEN) : chunk;
  assign sec_wr   = !to_mem_q;
  assign sec_lba  = lba_q;
  assign sec_len  = chunk;
  assign busy     = (st != S_IDLE);
  assign stg_ack  = (mem_req && mem_ack) || (sec_req && sec_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      to_mem_q <= 1'b0;
      opt_q    <= 1'b0;
      eot_q    <= 1'b0;
      tleft    <= '0;
      xfer     <= '0;
      dleft    <= '0;
      doff     <= '0;
      dbase    <= '0;
      lba_q    <= '0;
      active   <= 1'b0;
      dma_err  <= 1'b0;
      drv_stat <= STAT_IDLE;
      done     <= 1'b0;
      err      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      irq  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          to_mem_q <= dir_to_mem;
          opt_q    <= optical;
          tleft    <= total_len;
          xfer     <= '0;
          lba_q    <= lba_in;
          active   <= 1'b1;
          dma_err  <= 1'b0;
          drv_stat <= STAT_BUSY;
          st       <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          dbase <= mem_rdata[ADDR_W-1:0];
          dleft <= (rd_cnt == '0) ? DLEFT_W'(1) << DCNT_W : DLEFT_W'(rd_cnt);
          eot_q <= mem_rdata[DESC_W-1];
          doff  <= '0;
          st    <= S_STG1;
        end
        S_STG1: if (stg_ack) st <= S_STG2;
        S_STG2: if (stg_ack) begin
          doff  <= doff + DLEFT_W'(chunk);
          dleft <= dleft - DLEFT_W'(chunk);
          xfer  <= xfer + LEN_W'(chunk);
          tleft <= tleft - LEN_W'(chunk);
          lba_q <= lba_q + 1'b1;
          st    <= last_chunk ? S_DEND : S_STG1;
        end
        S_DEND: begin
          if (misalign || (tleft != '0 && eot_q)) begin
            err      <= 1'b1;
            dma_err  <= 1'b1;
            active   <= 1'b0;
            drv_stat <= STAT_ERR;
            st       <= S_IDLE;
          end else if (tleft == '0) begin
            done <= 1'b1;
            irq  <= 1'b1;
            if (eot_q) begin
              drv_stat <= STAT_IDLE;
              active   <= 1'b0;
            end
            st <= S_IDLE;
          end else begin
            st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk #(
  parameter int ADDR_W   = 32,
  parameter int LBA_W    = 28,
  parameter int CHK_W    = 12,
  parameter int OPT_SECT = 2048
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CHK_W-1:0]  mem_len,
  input logic              mem_ack,
  input logic              sec_req,
  input logic [LBA_W-1:0]  sec_lba,
  input logic [CHK_W-1:0]  sec_len,
  input logic              sec_ack,
  input logic              busy,
  input logic              active,
  input logic              dma_err,
  input logic              done,
  input logic              err,
  input logic              irq
);
  a_r12_mem_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_we));

  a_r12_sec_hold: assert property (@(posedge clk) disable iff (rst)
    sec_req && !sec_ack |=> sec_req && $stable(sec_lba) && $stable(sec_len));

  a_r4_one_side: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && sec_req));

  a_r3_chunk_range: assert property (@(posedge clk) disable iff (rst)
    sec_req |-> (sec_len != '0) && (sec_len <= CHK_W'(OPT_SECT)));

  a_r8_err_response: assert property (@(posedge clk) disable iff (rst)
    err |-> !active && dma_err && !irq && !done);

  a_r10_done_irq: assert property (@(posedge clk) disable iff (rst)
    done |-> irq && !err && !busy);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !sec_req);
endmodule

bind sgdma_engine sgdma_engine_chk #(
  .ADDR_W(ADDR_W), .LBA_W(LBA_W), .CHK_W(CHK_W), .OPT_SECT(OPT_SECT)
) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_len(mem_len), .mem_ack(mem_ack), .sec_req(sec_req), .sec_lba(sec_lba),
  .sec_len(sec_len), .sec_ack(sec_ack), .busy(busy), .active(active),
  .dma_err(dma_err), .done(done), .err(err), .irq(irq)
);

// File: tb/test_sgdma_engine.sv
module test_sgdma_engine;
  localparam logic [31:0] TBL = 32'h0000_8000;

  typedef struct {
    bit         is_sec;
    logic [31:0] addr;
    int         len;
    bit         dirbit;
    int         lba;
    string      req;
  } txn_t;

  logic clk = 0, rst = 1;
  logic start = 0, dir_to_mem = 0, optical = 0, idx_clear = 0;
  logic [7:0]  sect_cnt = 0;
  logic [27:0] lba_in = 0;
  logic        mem_req, mem_we, mem_ack = 0, sec_req, sec_wr, sec_ack = 0;
  logic [31:0] mem_addr;
  logic [11:0] mem_len, sec_len;
  logic [48:0] mem_rdata = 0;
  logic [27:0] sec_lba;
  logic        busy, active, dma_err, done, err, irq;
  logic [7:0]  drv_stat;

  int n_tests = 0, n_fail = 0;
  logic [48:0] dtab [0:15];
  txn_t exp_q[$];
  int   m_idx = 0;
  bit   m_err, m_eot;

  always #5 clk = ~clk;

  sgdma_engine i_sgdma_engine (
    .clk(clk), .rst(rst), .start(start), .dir_to_mem(dir_to_mem), .optical(optical),
    .sect_cnt(sect_cnt), .lba_in(lba_in), .tbl_base(TBL), .idx_clear(idx_clear),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .sec_req(sec_req), .sec_wr(sec_wr),
    .sec_lba(sec_lba), .sec_len(sec_len), .sec_ack(sec_ack), .busy(busy),
    .active(active), .dma_err(dma_err), .drv_stat(drv_stat), .done(done),
    .err(err), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [48:0] mkd(input logic [31:0] base, input int cnt, input bit eot);
    return {eot, cnt[15:0], base};
  endfunction

  // behavioural model: expected request stream and outcome
  task automatic plan(input int sc, input bit opt, input bit tm, input int lba);
    int total, sect, xfer, dl, off, c;
    logic [48:0] d;
    txn_t t;
    total = ((sc == 0) ? 256 : sc) * 512;
    sect  = opt ? 2048 : 512;
    xfer  = 0;
    m_err = 0; m_eot = 0;
    forever begin
      t = '{0, TBL + 32'(8 * m_idx), 8, 0, 0, "R2"};
      exp_q.push_back(t);
      d  = dtab[m_idx];
      dl = (d[47:32] == 0) ? 65536 : int'(d[47:32]);
      off = 0;
      while (dl > 0 && total > 0) begin
        c = dl;
        if (total < c) c = total;
        if (sect < c)  c = sect;
        if (tm) begin
          exp_q.push_back('{1, 0, c, 0, lba, "R5"});
          exp_q.push_back('{0, d[31:0] + 32'(off), c, 1, 0, "R3"});
        end else begin
          exp_q.push_back('{0, d[31:0] + 32'(off), c, 0, 0, "R3"});
          exp_q.push_back('{1, 0, c, 1, lba, "R4"});
        end
        off += c; xfer += c; dl -= c; total -= c; lba++;
      end
      m_idx++;
      if ((xfer % sect) != 0 || (total > 0 && d[48])) begin m_err = 1; break; end
      if (total == 0) begin m_eot = d[48]; break; end
    end
  endtask

  // memory and drive responder, compares every accepted request with the model
  initial begin
    int mcnt = 0;
    txn_t t;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        mcnt++;
        if (mcnt >= 2) begin
          mcnt = 0;
          if (exp_q.size() == 0) chk(0, "R4", "unexpected mem request", mem_addr, 0);
          else begin
            t = exp_q.pop_front();
            chk(!t.is_sec, t.req, "mem port used", 1, t.is_sec ? 0 : 1);
            chk(mem_addr == t.addr, t.req, "mem_addr", mem_addr, t.addr);
            chk(int'(mem_len) == t.len, t.req, "mem_len", mem_len, t.len);
            chk(mem_we == t.dirbit, "R4", "mem_we", mem_we, t.dirbit);
          end
          if (mem_addr >= TBL && mem_addr < TBL + 128) mem_rdata = dtab[(mem_addr - TBL) >> 3];
          mem_ack = 1;
        end
      end
      if (sec_ack) sec_ack = 0;
      else if (sec_req) begin
        if (exp_q.size() == 0) chk(0, "R4", "unexpected sector request", sec_lba, 0);
        else begin
          t = exp_q.pop_front();
          chk(t.is_sec, t.req, "sector port used", 1, t.is_sec ? 1 : 0);
          chk(int'(sec_lba) == t.lba, "R5", "sec_lba", sec_lba, t.lba);
          chk(int'(sec_len) == t.len, "R3", "sec_len", sec_len, t.len);
          chk(sec_wr == t.dirbit, "R4", "sec_wr", sec_wr, t.dirbit);
        end
        sec_ack = 1;
      end
    end
  end

  task automatic run(input int sc, input bit opt, input bit tm, input int lba,
                     input bit clr, input bit poke);
    bit got_done = 0, got_err = 0, got_irq = 0;
    if (clr) begin
      @(negedge clk); idx_clear = 1;
      @(negedge clk); idx_clear = 0;
      m_idx = 0;
    end
    plan(sc, opt, tm, lba);
    @(negedge clk);
    start = 1; sect_cnt = 8'(sc); optical = opt; dir_to_mem = tm; lba_in = 28'(lba);
    @(negedge clk);
    start = 0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      if (poke && cyc == 5) begin start = 1; idx_clear = 1; end
      if (poke && cyc == 6) begin start = 0; idx_clear = 0; end
      @(negedge clk);
      got_done |= done; got_err |= err; got_irq |= irq;
      if (done || err) break;
    end
    chk(exp_q.size() == 0, "R4", "requests left over", exp_q.size(), 0);
    exp_q.delete();
    if (m_err) begin
      chk(got_err && !got_done && !got_irq, "R8", "error pulse only", {got_err, got_done, got_irq}, 3'b100);
      chk(drv_stat == 8'h41, "R9", "drv_stat after error", drv_stat, 8'h41);
      chk(!active && dma_err, "R8", "active/dma_err after error", {active, dma_err}, 2'b01);
    end else if (m_eot) begin
      chk(got_done && got_irq && !got_err, "R10", "done+irq", {got_done, got_irq, got_err}, 3'b110);
      chk(drv_stat == 8'h50, "R10", "drv_stat", drv_stat, 8'h50);
      chk(!active && !dma_err, "R10", "active/dma_err", {active, dma_err}, 2'b00);
    end else begin
      chk(got_done && got_irq && !got_err, "R11", "done+irq", {got_done, got_irq, got_err}, 3'b110);
      chk(drv_stat == 8'h80, "R11", "drv_stat kept busy", drv_stat, 8'h80);
      chk(active, "R11", "active kept", active, 1);
    end
    chk(!busy, "R7", "idle after run", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) dtab[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(drv_stat == 8'h50, "R1", "drv_stat", drv_stat, 8'h50);
    chk(!busy && !active && !dma_err, "R1", "busy/active/dma_err", {busy, active, dma_err}, 0);
    chk(!mem_req && !sec_req, "R1", "requests", {mem_req, sec_req}, 0);

    // R1 index 0 after reset, R3 single descriptor to memory
    dtab[0] = mkd(32'h0010_0000, 1024, 1);
    run(2, 0, 1, 100, 0, 0);
    // R4 memory to drive over two descriptors
    dtab[0] = mkd(32'h0020_0000, 512, 0);
    dtab[1] = mkd(32'h0030_0000, 1024, 1);
    run(3, 0, 0, 7, 1, 0);
    // R3 optical chunking
    dtab[0] = mkd(32'h0040_0000, 4096, 1);
    run(8, 1, 1, 50, 1, 0);
    // R8 misaligned descriptor end
    dtab[0] = mkd(32'h0050_0000, 256, 0);
    dtab[1] = mkd(32'h0060_0000, 768, 1);
    run(2, 0, 1, 0, 1, 0);
    // R9 table ends early
    dtab[0] = mkd(32'h0070_0000, 1024, 1);
    run(4, 0, 0, 9, 1, 0);
    // R11 finish without end-of-table
    dtab[0] = mkd(32'h0080_0000, 512, 0);
    run(1, 0, 1, 3, 1, 0);
    // R7 index kept (next fetch at entry 1), start/idx_clear while busy ignored
    dtab[1] = mkd(32'h0090_0000, 2048, 1);
    run(4, 0, 1, 20, 0, 1);
    // R6 zero sector count, zero byte count descriptors
    dtab[0] = mkd(32'h0100_0000, 0, 0);
    dtab[1] = mkd(32'h0200_0000, 0, 1);
    run(0, 0, 0, 1000, 1, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule